// File: doc/BRIEF.md
# Low-Power Wake Controller

This block decides when a device parked in a low-power state (sleep or stop) should come back to life. It has two ways to do this, and only one can be active at a time. The first is periodic sensing: a tick-driven timer pulses a high-side bias output, and on the last tick of each pulse the enabled wake inputs are compared with stored reference levels. The second is a timed wake: the device is woken after a fixed number of ticks spent in low power.

The host sets the mode and the per-input enables with a single configuration write while the device is awake. A write accepted at that time also captures the current input levels as the reference. A wake raises a one-cycle wake pulse and sets a sticky cause bit. The host reads the cause bits, together with the live input levels, from one status word, and that read clears the cause bits.

Top module: `wk_ctrl`

## Requirements
- R1: After reset, bias_o and wake_o are 0, all cause bits are 0, and the mode is off, so no wake occurs in low power until a configuration write is accepted.
- R2: A configuration write is accepted only while low_pwr_i is 0. A write made in low power changes neither the mode, the enables nor the reference.
- R3: cfg_data_i[N_IN] requests periodic sensing and cfg_data_i[N_IN+1] requests the timed wake. A write that requests both keeps the current mode unchanged, whether that mode is off, sensing or timed. A write that requests exactly one mode selects it. A write that requests neither turns waking off.
- R4: In sensing mode and in low power, the tick counter runs from 0 to SENSE_PERIOD-1 and wraps. bias_o is 1 while the count is SENSE_PERIOD-PULSE_W or more. bias_o is 0 outside low power and in every other mode.
- R5: On a tick where the count is SENSE_PERIOD-1 (the last tick of the bias pulse), each enabled input (cfg_data_i[i]=1 at the last accepted write) whose level differs from its reference sets cause bit stat_o[i]. In the next cycle wake_o pulses for one cycle.
- R6: A disabled input never sets its cause bit and never causes a wake, whatever its level does.
- R7: At every sensing instant, all references are reloaded from the inputs. A level that has already caused a wake does not wake the device again while it holds.
- R8: An accepted configuration write loads the reference from the input levels present in that cycle.
- R9: In timed mode and in low power, the FORCE_TICKS-th tick sets cause bit stat_o[N_IN] and produces a one-cycle wake_o pulse.
- R10: The tick counter is held at 0 outside low power, so every entry into low power starts a full period or delay.
- R11: The cause bits are sticky. A cycle with stat_rd_i=1 clears them, but a cause arriving in that same cycle stays set.
- R12: stat_o[2*N_IN:N_IN+1] shows the live levels of wake_in_i at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick enable |
| low_pwr_i | input | 1 | 1 while the device is in sleep or stop |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | N_IN+2 | Input enables, sensing request, timed request |
| stat_rd_i | input | 1 | Status read strobe, clears the cause bits |
| wake_in_i | input | N_IN | Wake input levels |
| bias_o | output | 1 | High-side bias enable for the sensed switches |
| wake_o | output | 1 | One-cycle wake request |
| stat_o | output | 2*N_IN+1 | {live inputs, timed cause, input causes} |

## Verification
A status read can land in the same cycle as a sensing instant or a timed expiry. The cause that arrives in that cycle must then survive the clear. The bench sets this up on purpose by asserting stat_rd_i on the expiry tick of a timed wake, and expects the timed cause bit to still read 1 afterwards. The constrained-random phase issues reads about one cycle in eight while random ticks and input changes are running, so reads also coincide with sensing instants in both modes. A cycle-level model in the bench predicts the cause bits after every such collision.

// File: rtl/wk_pkg.sv
package wk_pkg;
    typedef enum logic [1:0] {
        WK_OFF   = 2'd0,
        WK_SENSE = 2'd1,
        WK_TIMED = 2'd2
    } wk_mode_e;
endpackage

// File: rtl/wk_cfg.sv
module wk_cfg
    import wk_pkg::*;
#(
    parameter int N_IN = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            low_pwr_i,
    input  logic            cfg_wr_i,
    input  logic [N_IN+1:0] cfg_data_i,
    output logic            load_o,
    output logic [N_IN-1:0] en_o,
    output wk_mode_e        mode_o
);
    typedef struct packed {
        logic [N_IN-1:0] en;
        wk_mode_e        mode;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic       accept;
    logic       want_sense, want_timed;

    always_comb begin
        st_d       = st_q;
        accept     = cfg_wr_i && !low_pwr_i;
        want_sense = cfg_data_i[N_IN];
        want_timed = cfg_data_i[N_IN+1];
        if (accept) begin
            st_d.en = cfg_data_i[N_IN-1:0];
            if (want_sense && want_timed) begin
                st_d.mode = st_q.mode;
            end else if (want_sense) begin
                st_d.mode = WK_SENSE;
            end else if (want_timed) begin
                st_d.mode = WK_TIMED;
            end else begin
                st_d.mode = WK_OFF;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{en: '0, mode: WK_OFF};
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o = accept;
    assign en_o   = st_q.en;
    assign mode_o = st_q.mode;
endmodule

// File: rtl/wk_timebase.sv
module wk_timebase
    import wk_pkg::*;
#(
    parameter int SENSE_PERIOD = 8,
    parameter int PULSE_W      = 3,
    parameter int FORCE_TICKS  = 20
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     tick_i,
    input  logic     low_pwr_i,
    input  wk_mode_e mode_i,
    output logic     bias_o,
    output logic     sense_stb_o,
    output logic     force_stb_o
);
    localparam int MAX_LEN = (SENSE_PERIOD > FORCE_TICKS) ? SENSE_PERIOD : FORCE_TICKS;
    localparam int CW      = $clog2(MAX_LEN + 1);
    localparam logic [CW-1:0] SENSE_LAST = CW'(SENSE_PERIOD - 1);
    localparam logic [CW-1:0] FORCE_LAST = CW'(FORCE_TICKS - 1);
    localparam logic [CW-1:0] BIAS_FIRST = CW'(SENSE_PERIOD - PULSE_W);
    localparam logic [CW-1:0] ONE        = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tb_state_t;

    tb_state_t     st_d, st_q;
    logic          running;
    logic [CW-1:0] last;

    always_comb begin
        st_d    = st_q;
        running = low_pwr_i && (mode_i != WK_OFF);
        last    = (mode_i == WK_SENSE) ? SENSE_LAST : FORCE_LAST;
        if (!running) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = (st_q.cnt == last) ? '0 : st_q.cnt + ONE;
        end
        sense_stb_o = running && (mode_i == WK_SENSE) && tick_i && (st_q.cnt == SENSE_LAST);
        force_stb_o = running && (mode_i == WK_TIMED) && tick_i && (st_q.cnt == FORCE_LAST);
        bias_o      = running && (mode_i == WK_SENSE) && (st_q.cnt >= BIAS_FIRST);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wk_sense.sv
module wk_sense #(
    parameter int N_IN = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            load_i,
    input  logic            sense_stb_i,
    input  logic [N_IN-1:0] en_i,
    input  logic [N_IN-1:0] wake_in_i,
    output logic [N_IN-1:0] hit_o
);
    typedef struct packed {
        logic [N_IN-1:0] ref_lvl;
    } sn_state_t;

    sn_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i || sense_stb_i) begin
            st_d.ref_lvl = wake_in_i;
        end
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_cmp
        assign hit_o[i] = sense_stb_i && en_i[i] && (wake_in_i[i] != st_q.ref_lvl[i]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wk_ctrl.sv
module wk_ctrl
    import wk_pkg::*;
#(
    parameter int N_IN         = 2,
    parameter int SENSE_PERIOD = 8,
    parameter int PULSE_W      = 3,
    parameter int FORCE_TICKS  = 20
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              low_pwr_i,
    input  logic              cfg_wr_i,
    input  logic [N_IN+1:0]   cfg_data_i,
    input  logic              stat_rd_i,
    input  logic [N_IN-1:0]   wake_in_i,
    output logic              bias_o,
    output logic              wake_o,
    output logic [2*N_IN:0]   stat_o
);
    localparam int NF = N_IN + 1;

    typedef struct packed {
        logic [NF-1:0] flags;
        logic          wake;
    } top_state_t;

    top_state_t      st_d, st_q;
    logic            cfg_load;
    logic [N_IN-1:0] en;
    wk_mode_e        mode;
    logic            sense_stb, force_stb;
    logic [N_IN-1:0] hit;
    logic [NF-1:0]   cause;

    wk_cfg #(.N_IN(N_IN)) u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .low_pwr_i  (low_pwr_i),
        .cfg_wr_i   (cfg_wr_i),
        .cfg_data_i (cfg_data_i),
        .load_o     (cfg_load),
        .en_o       (en),
        .mode_o     (mode)
    );

    wk_timebase #(
        .SENSE_PERIOD (SENSE_PERIOD),
        .PULSE_W      (PULSE_W),
        .FORCE_TICKS  (FORCE_TICKS)
    ) u_tb (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick_i),
        .low_pwr_i   (low_pwr_i),
        .mode_i      (mode),
        .bias_o      (bias_o),
        .sense_stb_o (sense_stb),
        .force_stb_o (force_stb)
    );

    wk_sense #(.N_IN(N_IN)) u_sense (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (cfg_load),
        .sense_stb_i (sense_stb),
        .en_i        (en),
        .wake_in_i   (wake_in_i),
        .hit_o       (hit)
    );

    always_comb begin
        st_d       = st_q;
        cause      = {force_stb, hit};
        st_d.flags = (stat_rd_i ? '0 : st_q.flags) | cause;
        st_d.wake  = |cause;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wake_o = st_q.wake;
    assign stat_o = {wake_in_i, st_q.flags};
endmodule

// File: rtl/wk_ctrl_chk.sv
module wk_ctrl_chk
    import wk_pkg::*;
#(
    parameter int N_IN = 2
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            low_pwr_i,
    input logic            stat_rd_i,
    input logic            bias_o,
    input logic            wake_o,
    input logic [2*N_IN:0] stat_o,
    input wk_mode_e        mode_i
);
    localparam int NF = N_IN + 1;

    // R11
    flags_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stat_rd_i |=> ((stat_o[NF-1:0] & $past(stat_o[NF-1:0])) == $past(stat_o[NF-1:0])));

    // R4
    bias_lp_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !low_pwr_i |-> !bias_o);

    // R4
    bias_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bias_o |-> (mode_i == WK_SENSE));

    // R5
    wake_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |=> !wake_o);

    // R9
    wake_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> (|stat_o[NF-1:0]));

    // R2
    mode_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        low_pwr_i |=> $stable(mode_i));
endmodule

bind wk_ctrl wk_ctrl_chk #(.N_IN(N_IN)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .low_pwr_i (low_pwr_i),
    .stat_rd_i (stat_rd_i),
    .bias_o    (bias_o),
    .wake_o    (wake_o),
    .stat_o    (stat_o),
    .mode_i    (mode)
);

// File: tb/wk_ctrl_test.sv
`timescale 1ns/1ps
module wk_ctrl_test;
    localparam int N  = 2;
    localparam int SP = 8;
    localparam int PW = 3;
    localparam int FT = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tk = 1'b0, lp = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [N+1:0] wd = '0;
    logic [N-1:0] win = '0;
    logic bias, wake;
    logic [2*N:0] stat;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // model state
    int m_mode = 0;          // 0 off, 1 sense, 2 timed
    int m_cnt = 0;
    logic [N-1:0] m_en = '0, m_ref = '0;
    logic [N:0] m_flags = '0;
    logic m_wake = 1'b0;

    always #4 clk = ~clk;

    wk_ctrl #(.N_IN(N), .SENSE_PERIOD(SP), .PULSE_W(PW), .FORCE_TICKS(FT)) uut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tk), .low_pwr_i(lp), .cfg_wr_i(wr),
        .cfg_data_i(wd), .stat_rd_i(rd), .wake_in_i(win),
        .bias_o(bias), .wake_o(wake), .stat_o(stat));

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic exp_bias();
        return lp && m_mode == 1 && m_cnt >= SP - PW;
    endfunction

    task automatic model_update();
        logic sense, frc, accept;
        logic [N-1:0] hits;
        logic cs, cf;
        accept = wr && !lp;
        sense  = lp && m_mode == 1 && tk && m_cnt == SP - 1;
        frc    = lp && m_mode == 2 && tk && m_cnt == FT - 1;
        hits   = sense ? ((win ^ m_ref) & m_en) : '0;
        m_flags = (rd ? '0 : m_flags) | {frc, hits};
        m_wake  = frc || (|hits);
        if (accept || sense) m_ref = win;
        if (!lp || m_mode == 0) m_cnt = 0;
        else if (tk) m_cnt = (m_cnt == ((m_mode == 1) ? SP : FT) - 1) ? 0 : m_cnt + 1;
        if (accept) begin
            m_en = wd[N-1:0];
            cs = wd[N];
            cf = wd[N+1];
            if (!(cs && cf)) m_mode = cs ? 1 : (cf ? 2 : 0);
        end
    endtask

    // one clock: compare all outputs against the model, then advance
    task automatic step(string ctx);
        #1;
        chk("R4",  {ctx, " bias"}, int'(bias), int'(exp_bias()));
        chk("R5",  {ctx, " wake"}, int'(wake), int'(m_wake));
        chk("R11", {ctx, " causes"}, int'(stat[N:0]), int'(m_flags));
        chk("R12", {ctx, " live"}, int'(stat[2*N:N+1]), int'(win));
        model_update();
        @(negedge clk);
        #1;
    endtask

    task automatic idle(int n, string ctx);
        for (int i = 0; i < n; i++) step(ctx);
    endtask

    task automatic cfg_write(logic [N+1:0] v);
        wr = 1'b1; wd = v; step("cfg");
        wr = 1'b0;
    endtask

    task automatic clear_status();
        rd = 1'b1; step("read");
        rd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        tk = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        #1;
        chk("R1", "bias after reset", int'(bias), 0);
        chk("R1", "wake after reset", int'(wake), 0);
        chk("R1", "causes after reset", int'(stat[N:0]), 0);
        lp = 1'b1;
        for (int k = 0; k < FT + 4; k++) step("R1 off");
        chk("R1", "no wake with mode off", int'(stat[N:0]), 0);
        lp = 1'b0; step("exit");

        // R12: live levels
        win = 2'b10; #1;
        chk("R12", "live levels", int'(stat[2*N:N+1]), 2);
        win = 2'b00; step("R12");

        // R8 R5 R7: sensing with both inputs enabled
        cfg_write(4'b0111);
        lp = 1'b1;
        for (int k = 0; k < 26; k++) begin
            if (k == 9) win = 2'b01;
            #1;
            chk("R4", "bias window", int'(bias), int'((k % SP) >= SP - PW));
            chk("R5", "wake after sensing instant", int'(wake), int'(k == 16));
            chk("R7", "no second wake", int'(stat[0]), int'(k >= 16));
            step("R5");
        end
        lp = 1'b0; step("exit");
        clear_status();

        // R6: only input 0 enabled; input 1 toggles
        win = 2'b00;
        cfg_write(4'b0101);
        lp = 1'b1;
        for (int k = 0; k < 2 * SP + 2; k++) begin
            if (k == 3) win = 2'b10;
            #1;
            chk("R6", "disabled input ignored", int'(stat[N:0]), 0);
            step("R6");
        end
        lp = 1'b0; step("exit");

        // R3: both requested keeps sensing
        cfg_write(4'b1100);
        lp = 1'b1;
        for (int k = 0; k < SP; k++) begin
            #1;
            chk("R3", "sensing kept", int'(bias), int'(k >= SP - PW));
            step("R3");
        end
        lp = 1'b0; step("exit");
        cfg_write(4'b1000);
        cfg_write(4'b1100);
        lp = 1'b1;
        for (int k = 0; k < FT + 2; k++) begin
            if (k == FT - 1) begin
                rd = 1'b1;   // R11: read collides with timed expiry
                wr = 1'b1;   // R2: write in low power ignored
                wd = 4'b0111;
            end else begin
                rd = 1'b0;
                wr = 1'b0;
            end
            #1;
            chk("R9", "timed wake", int'(wake), int'(k == FT));
            chk("R3", "timed kept, no bias", int'(bias), 0);
            step("R9");
        end
        rd = 1'b0; wr = 1'b0;
        #1;
        chk("R11", "cause survives same-cycle read", int'(stat[N]), 1);
        clear_status();
        #1;
        chk("R11", "read clears causes", int'(stat[N:0]), 0);
        // R2: timed mode still in force after the ignored write
        for (int k = 0; k < FT + 1; k++) step("R2");
        #1;
        chk("R2", "mode unchanged by low-power write", int'(stat[N]), 1);
        lp = 1'b0; step("exit");
        clear_status();

        // R10: leaving low power restarts the delay
        lp = 1'b1; idle(10, "R10");
        lp = 1'b0; step("R10");
        lp = 1'b1;
        for (int k = 0; k < FT + 1; k++) begin
            #1;
            chk("R10", "delay restarted", int'(wake), int'(k == FT));
            step("R10");
        end
        lp = 1'b0; step("exit");

        // R3: off mode with both requested stays off
        cfg_write(4'b0000);
        cfg_write(4'b1100);
        clear_status();
        lp = 1'b1; idle(FT + 5, "R3 off");
        #1;
        chk("R3", "stays off", int'(stat[N:0]), 0);
        lp = 1'b0; step("exit");

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(39) == 0) lp = ~lp;
            tk = ($urandom_range(3) != 0);
            wr = ($urandom_range(5) == 0);
            wd = 4'($urandom_range(15));
            rd = ($urandom_range(7) == 0);
            for (int b = 0; b < N; b++)
                if ($urandom_range(11) == 0) win[b] = ~win[b];
            step("random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule